// File: doc/BRIEF.md
# Isolated I/O Port Bank Decoder

This block sits on a processor's isolated I/O bus and provides a bank of eight byte-wide output ports and eight byte-wide input ports. Each bus cycle presents a 16-bit address, an I/O qualifier and active-low read and write strobes. A partial decode accepts a cycle only when the top address bit is 1 and the lowest address bit is 0. Address bits 3:1 then select one of the eight ports.

For a write, the bus data is held only briefly. The block therefore samples the address and data while the write strobe is low. It commits the sample to the selected output latch when the strobe returns high, and the latch keeps that value until the next write that selects it. For a read, the block models a three-state buffer. An output-enable flag and the selected input byte drive the bus only while the read strobe is low and the cycle is selected.

All logic is synchronous to one clock with a synchronous active-low reset. The strobes are taken as levels sampled on that clock.

Top module: `io_port_bank`

## Requirements
- R1: A cycle selects a port only when `io_sel` is 1, `addr[15]` is 1 and `addr[0]` is 0.
- R2: `addr[3:1]` is the port number 0..7. Address 8002h selects port 1, 8000h selects port 0 and 800Eh selects port 7. Bits 14:4 are ignored, so aliases such as FFF2h reach the same port.
- R3: Output port n occupies `out_ports[8n+7:8n]`. On a selected write, the byte on `bus_wdata` and the address seen in the last clock with `wr_n` low are stored into the port on the first clock at which `wr_n` is seen high again. The port does not change while `wr_n` is still low.
- R4: A latched output byte keeps its value, whatever `bus_wdata` does, until the next selected write to that port. A write to one port leaves the other seven unchanged.
- R5: While `rd_n` is 0 on a selected cycle, `bus_oe` is 1 and `bus_rdata` equals input port `in_ports[8n+7:8n]` for the decoded n, in the same cycle.
- R6: A cycle that is not selected (no `io_sel`, `addr[15]`=0 or `addr[0]`=1) changes no output latch and leaves `bus_oe` at 0 and `bus_rdata` at 00h.
- R7: A clock edge with `rst_n` low sets every output port to 00h.
- R8: Bit 7 of output port 0 follows bit 7 of each successive write to port 0, so alternating writes toggle an indicator attached to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_sel | input | 1 | Qualifies the cycle as an I/O-space cycle |
| addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Data driven by the processor on writes |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| in_ports | input | 64 | Eight input port bytes, port n at bits 8n+7:8n |
| out_ports | output | 64 | Eight output latch bytes, port n at bits 8n+7:8n |
| bus_rdata | output | 8 | Byte placed on the bus during a selected read |
| bus_oe | output | 1 | Three-state enable for `bus_rdata` |

## Verification
Writes and reads are swept over all eight port numbers at the base address and again at a fully aliased address. Each port receives a distinct arithmetic byte, so a wrong index or a write that leaks into a neighbouring port shows up as a mismatch. The same sweeps are then repeated with each of the three qualifiers spoiled in turn. These runs separate a decode that ignores a qualifier from a correct one, because the latches must keep their old bytes and the bus enable must stay low. A port is also sampled mid-strobe, and the write data is wiggled after a write, to tell trailing-edge capture apart from transparent or early capture. Alternating bit-7 writes to port 0 exercise the indicator.

// File: rtl/io_port_bank_pkg.sv
// Package: shared widths and the commit record passed from the strobe
// capture stage to the output latch bank.
package io_port_bank_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 16;
    localparam int PIDX_W   = 3;
    localparam int NPORTS   = 1 << PIDX_W;

    typedef struct packed {
        logic              valid;
        logic [PIDX_W-1:0] idx;
        logic [BYTE_W-1:0] data;
    } wr_commit_t;
endpackage

// File: rtl/io_addr_decode.sv
// Module: partial address decoder.
// Accepts a cycle when the qualifier is set, the top address bit is 1 and
// bit 0 is 0; bits PIDX_W:1 give the port index. Middle bits are ignored.
// Assumes ADDR_W > PIDX_W + 1.
module io_addr_decode #(
    parameter int ADDR_W = 16,
    parameter int PIDX_W = 3
) (
    input  logic              io_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [PIDX_W-1:0] idx
);
    localparam int QUAL_HI = ADDR_W - 1;

    // Qualify the cycle and extract the port index.
    always_comb begin
        hit = io_sel && addr[QUAL_HI] && !addr[0];
        idx = addr[PIDX_W:1];
    end
endmodule

// File: rtl/io_wr_capture.sv
// Module: write strobe capture.
// Samples the decode result and bus data on every clock while the write
// strobe is low, and issues a one-cycle commit when the strobe is seen high
// after being low. Assumes the strobe is synchronous to clk.
module io_wr_capture
    import io_port_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              hit,
    input  logic [PIDX_W-1:0] idx,
    input  logic [BYTE_W-1:0] wdata,
    output wr_commit_t        commit
);
    logic              wr_n_q;
    logic              smp_hit;
    logic [PIDX_W-1:0] smp_idx;
    logic [BYTE_W-1:0] smp_data;

    // Track the previous strobe level for trailing-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_n_q <= 1'b1;
        else        wr_n_q <= wr_n;
    end

    // Hold the most recent address decode and data seen with the strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_hit  <= 1'b0;
            smp_idx  <= '0;
            smp_data <= '0;
        end else if (!wr_n) begin
            smp_hit  <= hit;
            smp_idx  <= idx;
            smp_data <= wdata;
        end
    end

    // Commit on the low-to-high strobe transition.
    always_comb begin
        commit.valid = wr_n && !wr_n_q && smp_hit;
        commit.idx   = smp_idx;
        commit.data  = smp_data;
    end
endmodule

// File: rtl/io_out_latch_bank.sv
// Module: bank of output byte latches.
// Each port register loads on a commit addressed to it and otherwise holds.
// All registers clear to zero on synchronous reset.
module io_out_latch_bank
    import io_port_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  wr_commit_t               commit,
    output logic [NPORTS*BYTE_W-1:0] out_ports
);
    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        logic [BYTE_W-1:0] q;

        // Load this port's byte on a matching commit.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (commit.valid && commit.idx == PIDX_W'(g))
                q <= commit.data;
        end

        assign out_ports[g*BYTE_W +: BYTE_W] = q;
    end
endmodule

// File: rtl/io_rd_mux.sv
// Module: read path, modelling the three-state input buffers.
// Enables the bus only during a selected read and routes the indexed byte;
// drives zero when disabled.
module io_rd_mux
    import io_port_bank_pkg::*;
(
    input  logic                     rd_n,
    input  logic                     hit,
    input  logic [PIDX_W-1:0]        idx,
    input  logic [NPORTS*BYTE_W-1:0] in_ports,
    output logic [BYTE_W-1:0]        rdata,
    output logic                     oe
);
    // Select and gate the input byte.
    always_comb begin
        oe    = hit && !rd_n;
        rdata = oe ? in_ports[idx*BYTE_W +: BYTE_W] : '0;
    end
endmodule

// File: rtl/io_port_bank.sv
// Module: top of the isolated I/O port bank.
// Eight output latches and eight input ports behind a partial decoder.
// Assumes strobes synchronous to clk; reset is synchronous, active low.
module io_port_bank
    import io_port_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     io_sel,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BYTE_W-1:0]        bus_wdata,
    input  logic                     wr_n,
    input  logic                     rd_n,
    input  logic [NPORTS*BYTE_W-1:0] in_ports,
    output logic [NPORTS*BYTE_W-1:0] out_ports,
    output logic [BYTE_W-1:0]        bus_rdata,
    output logic                     bus_oe
);
    logic              dec_hit;
    logic [PIDX_W-1:0] dec_idx;
    wr_commit_t        commit;

    io_addr_decode #(.ADDR_W(ADDR_W), .PIDX_W(PIDX_W)) u_dec (
        .io_sel (io_sel),
        .addr   (addr),
        .hit    (dec_hit),
        .idx    (dec_idx)
    );

    io_wr_capture u_wcap (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n   (wr_n),
        .hit    (dec_hit),
        .idx    (dec_idx),
        .wdata  (bus_wdata),
        .commit (commit)
    );

    io_out_latch_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .out_ports (out_ports)
    );

    io_rd_mux u_rd (
        .rd_n     (rd_n),
        .hit      (dec_hit),
        .idx      (dec_idx),
        .in_ports (in_ports),
        .rdata    (bus_rdata),
        .oe       (bus_oe)
    );
endmodule

// File: rtl/io_port_bank_chk.sv
// Module: property checker for io_port_bank, attached by bind.
// Observes top-level ports only.
module io_port_bank_chk
    import io_port_bank_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     io_sel,
    input logic [ADDR_W-1:0]        addr,
    input logic                     wr_n,
    input logic                     rd_n,
    input logic [NPORTS*BYTE_W-1:0] in_ports,
    input logic [NPORTS*BYTE_W-1:0] out_ports,
    input logic [BYTE_W-1:0]        bus_rdata,
    input logic                     bus_oe
);
    AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (io_sel && addr[ADDR_W-1] && !addr[0] && !rd_n)); // R6

    AST_RDATA_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_rdata == in_ports[addr[PIDX_W:1]*BYTE_W +: BYTE_W])); // R5

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_rdata == '0)); // R6

    AST_HOLD_NO_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_n && !$past(wr_n)) |=> $stable(out_ports)); // R4

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (out_ports == '0)); // R7
endmodule

bind io_port_bank io_port_bank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_sel    (io_sel),
    .addr      (addr),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .in_ports  (in_ports),
    .out_ports (out_ports),
    .bus_rdata (bus_rdata),
    .bus_oe    (bus_oe)
);

// File: tb/tb_io_port_bank.sv
module tb_io_port_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_sel = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [63:0] in_ports = '0;
    logic [63:0] out_ports;
    logic [7:0]  bus_rdata;
    logic        bus_oe;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    logic [7:0] exp_out [8];

    always #10 clk = ~clk; // 50 MHz

    io_port_bank dut (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .addr(addr),
        .bus_wdata(bus_wdata), .wr_n(wr_n), .rd_n(rd_n),
        .in_ports(in_ports), .out_ports(out_ports),
        .bus_rdata(bus_rdata), .bus_oe(bus_oe)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_vec();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = exp_out[i];
        return v;
    endfunction

    function automatic bit selects(input logic sel, input logic [15:0] a);
        return sel && a[15] && !a[0];
    endfunction

    // One write cycle; checks that nothing moves while the strobe is low.
    task automatic do_write(input string req, input logic sel, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_sel = sel; addr = a; bus_wdata = d; wr_n = 1'b0;
        @(negedge clk);
        check({req, "/R3 mid-strobe"}, out_ports, exp_vec());
        wr_n = 1'b1; io_sel = 1'b0; addr = 16'h0; bus_wdata = ~d;
        @(negedge clk);
        if (selects(sel, a)) exp_out[a[3:1]] = d;
        check(req, out_ports, exp_vec());
    endtask

    // One read cycle; bus checked in the same cycle.
    task automatic do_read(input string req, input logic sel, input logic [15:0] a);
        @(negedge clk);
        io_sel = sel; addr = a; rd_n = 1'b0;
        #1;
        if (selects(sel, a))
            check(req, {55'd0, bus_oe, bus_rdata}, {55'd0, 1'b1, in_ports[a[3:1]*8 +: 8]});
        else
            check(req, {55'd0, bus_oe, bus_rdata}, 64'd0);
        @(negedge clk);
        rd_n = 1'b1; io_sel = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            exp_out[i] = 8'h00;
            in_ports[i*8 +: 8] = 8'(i * 29 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset clears", out_ports, 64'd0);
        check("R6 idle bus", {55'd0, bus_oe, bus_rdata}, 64'd0);

        // Named addresses
        do_write("R2 8002h->port1", 1'b1, 16'h8002, 8'hA5);
        do_write("R2 8000h->port0", 1'b1, 16'h8000, 8'h3C);
        do_read ("R2 800Eh->in7", 1'b1, 16'h800E);

        // Sweep all ports, base and aliased addresses
        for (int p = 0; p < 8; p++) begin
            do_write("R3 sweep base", 1'b1, 16'h8000 | 16'(p << 1), 8'(p * 37 + 11));
            do_read ("R5 sweep base", 1'b1, 16'h8000 | 16'(p << 1));
        end
        for (int p = 0; p < 8; p++) begin
            do_write("R2 alias write", 1'b1, 16'hFFF0 | 16'(p << 1), 8'(p * 53 + 200));
            do_read ("R2 alias read", 1'b1, 16'hBAB0 | 16'(p << 1));
        end

        // Hold: wiggle write data without a strobe
        @(negedge clk); bus_wdata = 8'h5A; io_sel = 1'b1; addr = 16'h8004;
        @(negedge clk); bus_wdata = 8'hC3;
        @(negedge clk); io_sel = 1'b0;
        check("R4 hold without strobe", out_ports, exp_vec());

        // Unqualified cycles across all ports
        for (int p = 0; p < 8; p++) begin
            do_write("R1 no io_sel", 1'b0, 16'h8000 | 16'(p << 1), 8'hEE);
            do_write("R1 a15 low", 1'b1, 16'h0000 | 16'(p << 1), 8'hDD);
            do_write("R1 a0 high", 1'b1, 16'h8001 | 16'(p << 1), 8'hCC);
            do_read ("R6 no io_sel", 1'b0, 16'h8000 | 16'(p << 1));
            do_read ("R6 a15 low", 1'b1, 16'h7FF0 | 16'(p << 1));
            do_read ("R6 a0 high", 1'b1, 16'h8001 | 16'(p << 1));
        end

        // Indicator on port 0 bit 7
        for (int k = 0; k < 4; k++) begin
            do_write("R8 indicator", 1'b1, 16'h8000, (k % 2 == 0) ? 8'h80 : 8'h00);
            check("R8 bit7 level", {63'd0, out_ports[7]}, {63'd0, (k % 2 == 0)});
        end

        // Reset in mid-run clears all latches
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 8; i++) exp_out[i] = 8'h00;
        check("R7 reset after writes", out_ports, exp_vec());

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule